// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates eight interrupt levels for a small processor core. Eight hardware request lines and a software-interrupt strobe from the CPU are recorded in a pending register. A second register records the levels whose service routines have started and not yet returned. Level 7 outranks every other level and level 0 is the lowest. A pending level is dispatched only when the global enable flag is set and the level is strictly above every level already in service, so only a higher level can interrupt a running routine.

A dispatch is a one-cycle acknowledge pulse to the core. The pulse carries the 3-bit level and a service address, which is `VEC_BASE + level * VEC_STRIDE`. When the core finishes a routine it pulses the return input. The controller then retires the highest level in service, which is always the most recently entered one. Request sampling is suspended on cycles the core marks as I/O cycles. While a level's pending bit is set, a further request for that level merges into the one already recorded.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While rst_n is low the pending register, the active register and the enable flag are all zero, and ack_valid_o is low.
- R2: On a clock edge with io_cycle_i low, each irq_req_i bit that is high sets the pending bit of that level (pend_o bit n = level n) at that edge.
- R3: On a clock edge with io_cycle_i high, no request from irq_req_i or the software strobe is recorded, and the request is not retained.
- R4: Among pending levels that are not active, the highest-numbered level is dispatched first (7 highest, 0 lowest).
- R5: A pending level is dispatched only if it is strictly higher than every set bit of act_o. Equal or lower levels wait until the higher levels have returned.
- R6: The enable flag (irq_en_o) is set by ie_set_i and cleared by ie_clr_i, and clear wins when both are high. While it is zero, requests are still recorded but none is dispatched. Deferred requests are dispatched after it is set.
- R7: A dispatch is a one-cycle pulse on ack_valid_o with ack_lvl_o holding the level and ack_vec_o = VEC_BASE + level*VEC_STRIDE. The level's act_o bit is set at the same edge.
- R8: A pulse on rti_i clears both the active and the pending bit of the highest set bit of act_o. A request for that level in the same cycle is recorded after the clear.
- R9: A request for a level whose pending bit is already set has no effect, so one service follows however many requests arrived.
- R10: With the enable flag set, nothing active and no I/O cycles, ack_valid_o is high after the third clock edge that follows a request being presented, and low after the first two.
- R11: A pulse on sw_irq_stb_i records a request at level sw_irq_lvl_i, and that request is then arbitrated and dispatched like a hardware request of that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| irq_req_i | input | 8 | Hardware request lines, bit n = level n |
| sw_irq_stb_i | input | 1 | Software interrupt strobe from the CPU |
| sw_irq_lvl_i | input | 3 | Level of the software interrupt |
| io_cycle_i | input | 1 | Current cycle is an I/O instruction cycle |
| rti_i | input | 1 | Return-from-interrupt pulse from the core |
| ie_set_i | input | 1 | Set the global interrupt enable flag |
| ie_clr_i | input | 1 | Clear the global interrupt enable flag |
| ack_valid_o | output | 1 | One-cycle acknowledge request to the core |
| ack_lvl_o | output | 3 | Level being acknowledged |
| ack_vec_o | output | VEC_W | Service routine address for the acknowledged level |
| pend_o | output | 8 | Pending register |
| act_o | output | 8 | Active register |
| irq_en_o | output | 1 | Global interrupt enable flag |

## Verification
Suppose the active register wrongly lost a level. The next cycle, act_o would disagree with the reference, and within three edges a lower or equal level would be acknowledged while the interrupted routine is still running. Suppose instead a pending bit was dropped or spuriously set. pend_o shows it at the very next edge, and a missing or unexpected acknowledge follows two edges later. The reference model is compared with every output on every clock. This catches a latency that is off by one edge as well as a level, vector or return clear aimed at the wrong level.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int unsigned PIC_LVLS  = 8;
    localparam int unsigned PIC_IDX_W = $clog2(PIC_LVLS);

    typedef logic [PIC_LVLS-1:0]  lvl_vec_t;
    typedef logic [PIC_IDX_W-1:0] lvl_idx_t;

    // Registered state of the arbitration and dispatch path.
    typedef struct packed {
        lvl_vec_t act;   // levels in service
        logic     gie;   // global enable
        logic     cvld;  // candidate stage valid
        lvl_idx_t clvl;  // candidate level
        logic     ack;   // acknowledge pulse
        lvl_idx_t alvl;  // acknowledged level
    } disp_st_t;

    function automatic lvl_vec_t lvl_onehot(input lvl_idx_t idx);
        return lvl_vec_t'(1) << idx;
    endfunction

endpackage

// File: rtl/prio_irq_enc.sv
module prio_irq_enc #(
    parameter int unsigned N = 8,
    parameter int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    output logic         any_o,
    output logic [W-1:0] idx_o
);
    // Highest-numbered set bit wins: later iterations override earlier ones.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) begin
                any_o = 1'b1;
                idx_o = W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_pend.sv
module prio_irq_pend
    import prio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lvl_vec_t req_i,
    input  logic     io_i,
    input  lvl_vec_t clr_i,
    output lvl_vec_t pend_o
);
    lvl_vec_t pend_d, pend_q;

    // Per level: the return clear applies first, then a sampled request ORs in.
    // A request on an already set bit merges into it and is lost.
    for (genvar g = 0; g < PIC_LVLS; g++) begin : g_bit
        always_comb begin
            pend_d[g] = (pend_q[g] & ~clr_i[g]) | (req_i[g] & ~io_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // R3: an I/O cycle never adds a new pending bit
    p_io_no_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        io_i |=> ((pend_q & ~$past(pend_q)) == '0));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int unsigned          VEC_W      = 8,
    parameter logic [VEC_W-1:0]     VEC_BASE   = 8'h40,
    parameter logic [VEC_W-1:0]     VEC_STRIDE = 8'h04
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIC_LVLS-1:0]  irq_req_i,
    input  logic                 sw_irq_stb_i,
    input  logic [PIC_IDX_W-1:0] sw_irq_lvl_i,
    input  logic                 io_cycle_i,
    input  logic                 rti_i,
    input  logic                 ie_set_i,
    input  logic                 ie_clr_i,
    output logic                 ack_valid_o,
    output logic [PIC_IDX_W-1:0] ack_lvl_o,
    output logic [VEC_W-1:0]     ack_vec_o,
    output logic [PIC_LVLS-1:0]  pend_o,
    output logic [PIC_LVLS-1:0]  act_o,
    output logic                 irq_en_o
);
    disp_st_t st_d, st_q;
    lvl_vec_t pend_q, req_vec, clr_vec, wait_vec;
    logic     hi_any, win_any, fire;
    lvl_idx_t hi_idx, win_idx;

    // Hardware lines and the software strobe merge into one request vector.
    always_comb begin
        req_vec = irq_req_i;
        if (sw_irq_stb_i) req_vec = req_vec | lvl_onehot(sw_irq_lvl_i);
    end

    // Highest level in service, and highest pending level not yet in service.
    assign wait_vec = pend_q & ~st_q.act;

    prio_irq_enc #(.N(PIC_LVLS), .W(PIC_IDX_W)) u_enc_act (
        .vec_i (st_q.act),
        .any_o (hi_any),
        .idx_o (hi_idx)
    );

    prio_irq_enc #(.N(PIC_LVLS), .W(PIC_IDX_W)) u_enc_win (
        .vec_i (wait_vec),
        .any_o (win_any),
        .idx_o (win_idx)
    );

    // Return retires the innermost nested level.
    assign clr_vec = (rti_i && hi_any) ? lvl_onehot(hi_idx) : '0;

    prio_irq_pend u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_vec),
        .io_i   (io_cycle_i),
        .clr_i  (clr_vec),
        .pend_o (pend_q)
    );

    always_comb begin
        st_d = st_q;

        // Dispatch stage: re-qualify the registered candidate against current state.
        fire = st_q.cvld && st_q.gie && pend_q[st_q.clvl] && !st_q.act[st_q.clvl]
            && (!hi_any || (st_q.clvl > hi_idx));

        st_d.act = st_q.act & ~clr_vec;
        if (fire) st_d.act = st_d.act | lvl_onehot(st_q.clvl);

        st_d.ack = fire;
        if (fire) st_d.alvl = st_q.clvl;

        // Candidate stage: one candidate in flight at a time.
        st_d.cvld = !st_q.cvld && st_q.gie && win_any && (!hi_any || (win_idx > hi_idx));
        st_d.clvl = win_idx;

        // Enable flag: clear has precedence.
        if (ie_clr_i)      st_d.gie = 1'b0;
        else if (ie_set_i) st_d.gie = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_valid_o = st_q.ack;
    assign ack_lvl_o   = st_q.alvl;
    assign ack_vec_o   = VEC_BASE + VEC_STRIDE * VEC_W'(st_q.alvl);
    assign pend_o      = pend_q;
    assign act_o       = st_q.act;
    assign irq_en_o    = st_q.gie;

    // R6: no acknowledge unless the flag was set before the dispatching edge
    p_ack_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ack |-> $past(st_q.gie));

    // R7: acknowledged level is marked active with the pulse
    p_ack_marks_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ack |-> st_q.act[st_q.alvl]);

    // R7: acknowledge is a single-cycle pulse
    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ack |=> !st_q.ack);

    // R5: the acknowledged level is the highest one in service
    p_nest_strict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ack |-> ((st_q.act >> st_q.alvl) == lvl_vec_t'(1)));

    // R8: every active level still has its pending bit
    p_active_in_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act & ~pend_q) == '0);

    // R8: a return removes the innermost active level
    p_rti_retires_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_i && hi_any) |=> !st_q.act[$past(hi_idx)]);

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_req = '0;
    logic       sw_stb = 1'b0;
    logic [2:0] sw_lvl = '0;
    logic       io_cyc = 1'b0;
    logic       rti = 1'b0;
    logic       ie_set = 1'b0;
    logic       ie_clr = 1'b0;
    logic       ack_valid;
    logic [2:0] ack_lvl;
    logic [7:0] ack_vec;
    logic [7:0] pend, act;
    logic       irq_en;

    int checks = 0;
    int errors = 0;
    int ack_cnt = 0;
    int cyc = 0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk (clk), .rst_n (rst_n),
        .irq_req_i (irq_req), .sw_irq_stb_i (sw_stb), .sw_irq_lvl_i (sw_lvl),
        .io_cycle_i (io_cyc), .rti_i (rti), .ie_set_i (ie_set), .ie_clr_i (ie_clr),
        .ack_valid_o (ack_valid), .ack_lvl_o (ack_lvl), .ack_vec_o (ack_vec),
        .pend_o (pend), .act_o (act), .irq_en_o (irq_en)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_pend, m_act;
    logic       m_gie, m_cand, m_ack;
    int         m_clvl, m_alvl;

    function automatic int top_bit(input logic [7:0] v);
        int r = -1;
        for (int i = 0; i < 8; i++) if (v[i]) r = i;
        return r;
    endfunction

    always @(posedge clk) begin
        int ha, hw;
        logic [7:0] rq, cl;
        logic go;
        if (!rst_n) begin
            m_pend = '0; m_act = '0; m_gie = 0; m_cand = 0; m_ack = 0;
            m_clvl = 0; m_alvl = 0;
        end else begin
            ha = top_bit(m_act);
            hw = top_bit(m_pend & ~m_act);
            rq = irq_req;
            if (sw_stb) rq[sw_lvl] = 1'b1;
            if (io_cyc) rq = '0;
            cl = '0;
            if (rti && ha >= 0) cl[ha] = 1'b1;
            go = m_cand && m_gie && m_pend[m_clvl] && !m_act[m_clvl] && (m_clvl > ha);
            m_act = m_act & ~cl;
            if (go) begin
                m_act[m_clvl] = 1'b1;
                m_alvl = m_clvl;
            end
            m_ack = go;
            m_pend = (m_pend & ~cl) | rq;
            if (!m_cand && m_gie && hw >= 0 && hw > ha) begin
                m_cand = 1'b1;
                m_clvl = hw;
            end else begin
                m_cand = 1'b0;
            end
            if (ie_clr)      m_gie = 1'b0;
            else if (ie_set) m_gie = 1'b1;
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, cyc, actual, expected);
        end
    endtask

    // One clock: advance, then compare every output with the model away from the edge.
    task automatic tick();
        @(posedge clk);
        #1;
        check("R2 pending", int'(pend), int'(m_pend));
        check("R5 active", int'(act), int'(m_act));
        check("R6 enable", int'(irq_en), int'(m_gie));
        check("R7 ack_valid", int'(ack_valid), int'(m_ack));
        if (ack_valid) begin
            ack_cnt++;
            check("R7 ack level", int'(ack_lvl), m_alvl);
            check("R7 vector", int'(ack_vec), 'h40 + 4 * int'(ack_lvl));
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse_irq(input logic [7:0] v);
        irq_req = v; tick(); irq_req = '0;
    endtask

    task automatic pulse_rti();
        rti = 1'b1; tick(); rti = 1'b0;
    endtask

    task automatic wait_ack(input string req, input int lvl);
        logic seen = 1'b0;
        for (int i = 0; i < 8 && !seen; i++) begin
            tick();
            if (ack_valid) begin
                seen = 1'b1;
                check(req, int'(ack_lvl), lvl);
            end
        end
        if (!seen) check(req, -1, lvl);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !finished) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 pend reset", int'(pend), 0);
        check("R1 act reset", int'(act), 0);
        check("R1 enable reset", int'(irq_en), 0);
        check("R1 ack reset", int'(ack_valid), 0);
        rst_n = 1'b1;
        tick();

        // R6: logged while disabled, dispatched after enabling
        pulse_irq(8'h10);
        ticks(5);
        check("R6 logged while off", int'(pend[4]), 1);
        check("R6 no ack while off", ack_cnt, 0);
        ie_set = 1'b1; tick(); ie_set = 1'b0;
        wait_ack("R6 deferred dispatch", 4);
        check("R7 vector level 4", int'(ack_vec), 'h50);
        check("R7 active bit", int'(act), 'h10);
        pulse_rti();
        check("R8 rti clears act", int'(act), 0);
        check("R8 rti clears pend", int'(pend), 0);

        // R10 latency, R2 sampling
        irq_req = 8'h08; tick(); irq_req = '0;
        check("R2 sampled", int'(pend[3]), 1);
        check("R10 not after edge 1", int'(ack_valid), 0);
        tick();
        check("R10 not after edge 2", int'(ack_valid), 0);
        tick();
        check("R10 ack after edge 3", int'(ack_valid), 1);
        check("R10 level", int'(ack_lvl), 3);

        // R5 nesting: lower waits, higher nests
        n0 = ack_cnt;
        pulse_irq(8'h02);
        ticks(5);
        check("R5 lower waits", ack_cnt, n0);
        check("R5 lower pending", int'(pend[1]), 1);
        pulse_irq(8'h20);
        wait_ack("R5 higher nests", 5);
        check("R5 nested active", int'(act), 'h28);

        // R9: repeat request while pending is lost
        pulse_irq(8'h20);
        pulse_rti();
        check("R9 repeat lost", int'(pend[5]), 0);
        n0 = ack_cnt;
        ticks(4);
        check("R9 single service", ack_cnt, n0);
        pulse_rti();
        wait_ack("R5 lower after return", 1);
        pulse_rti();

        // R3: I/O cycle skips sampling
        io_cyc = 1'b1; irq_req = 8'h40; tick(); io_cyc = 1'b0; irq_req = '0;
        check("R3 io no sample", int'(pend), 0);
        n0 = ack_cnt;
        ticks(5);
        check("R3 io no ack", ack_cnt, n0);

        // R4: simultaneous requests, highest first
        pulse_irq(8'h44);
        wait_ack("R4 highest first", 6);
        pulse_rti();
        wait_ack("R4 next lower", 2);
        pulse_rti();

        // R11: software interrupt
        sw_lvl = 3'd7; sw_stb = 1'b1; tick(); sw_stb = 1'b0;
        wait_ack("R11 sw dispatch", 7);
        check("R11 sw vector", int'(ack_vec), 'h5C);
        pulse_rti();

        // R8: request in the return cycle is recorded after the clear
        pulse_irq(8'h01);
        wait_ack("R8 level 0", 0);
        rti = 1'b1; irq_req = 8'h01; tick(); rti = 1'b0; irq_req = '0;
        check("R8 same-cycle request kept", int'(pend[0]), 1);
        check("R8 same-cycle act cleared", int'(act[0]), 0);
        wait_ack("R8 re-dispatch", 0);
        pulse_rti();

        // R6: clear wins over set
        ie_set = 1'b1; ie_clr = 1'b1; tick(); ie_set = 1'b0; ie_clr = 1'b0;
        check("R6 clear wins", int'(irq_en), 0);
        ticks(2);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule